// File: doc/BRIEF.md
# Warp Memory Request Coalescer

One SIMT load or store instruction presents a vector of per-thread requests. Each thread has an enable bit, a byte address and, for stores, one data word. This block turns that vector into the smallest set of line-sized transactions toward the cache. It emits at most one transaction per cycle. In every issue cycle it takes the lowest-numbered thread that is still pending as the leader. It then gathers every pending thread whose line address (the address bits above the line offset) equals the leader's into that transaction, and retires those threads. The instruction is replayed in this way until no thread is left pending.

Each transaction carries the line number, a mask of the threads it covers, the byte offset of each of those threads inside the line, and a load/store flag. For stores it also carries the line-wide write data and byte enables assembled from the covered threads. Both sides use a valid/ready handshake. A new instruction is taken only once the previous one has fully drained. The line size is a power of two: 32, 64 or 128 bytes. It must be at least the size of one eight-beat burst on the memory channel.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, out_valid and out_done are low and in_ready is high.
- R2: in_ready is high exactly when no thread of the current instruction is pending. An instruction offered while in_ready is low is not taken and does not alter the transactions in flight.
- R3: Each transaction's leader is the lowest-numbered pending thread. out_line equals the leader's address shifted right by log2(LINE_BYTES). out_mask bit t is set exactly for the pending threads whose shifted address equals that value.
- R4: Once accepted and ready, exactly one transaction is issued per cycle in which out_ready is high, in ascending leader order. The number of transactions for an instruction equals the number of distinct line addresses among its active threads.
- R5: A thread whose in_active bit is clear never appears in any out_mask. An instruction with an all-zero active mask emits no transaction and raises out_done in the cycle it is accepted.
- R6: While out_valid is high and out_ready is low, every output field stays unchanged in the next cycle and no thread is retired.
- R7: Field t of out_offs (bits t*OFF_W up to t*OFF_W+OFF_W-1) holds the low log2(LINE_BYTES) address bits of thread t when out_mask bit t is set, and zero otherwise.
- R8: For a store, each covered thread's data byte b (little-endian, bits 8b to 8b+7) lands at line byte offset+b. The corresponding out_be bit is set, and bytes beyond the end of the line are dropped. When two threads write the same byte, the higher-numbered thread wins. For a load, out_be and out_wdata are all zero and out_store is low.
- R9: out_done is high exactly in the cycle the final transaction of an instruction is accepted (out_valid and out_ready both high, with no other thread still pending).
- R10: Two addresses that differ only below bit log2(LINE_BYTES) are merged into one transaction. Two addresses that differ at that bit go into separate transactions.
- R11: When every active thread lies in a different line, the instruction issues one transaction per active thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Coalescer idle, instruction can be taken |
| in_store | input | 1 | 1 = store, 0 = load |
| in_active | input | THREADS | Per-thread enable |
| in_addr | input | THREADS*ADDR_W | Per-thread byte address, thread t at bits t*ADDR_W |
| in_wdata | input | THREADS*DATA_W | Per-thread store word, thread t at bits t*DATA_W |
| out_valid | output | 1 | Transaction available |
| out_ready | input | 1 | Cache accepts the transaction |
| out_store | output | 1 | Transaction is a store |
| out_line | output | ADDR_W-OFF_W | Line number |
| out_mask | output | THREADS | Threads covered by this transaction |
| out_offs | output | THREADS*OFF_W | Per-thread byte offset in the line |
| out_wdata | output | LINE_BYTES*8 | Assembled store data |
| out_be | output | LINE_BYTES | Store byte enables |
| out_done | output | 1 | Final transaction of the instruction accepted |

## Verification
The bench goes after the line boundary. Addresses one byte apart on either side of a line edge must split, and a design that takes the wrong bit would merge them or split same-line threads. It runs fully divergent and fully convergent vectors. A leader chosen from the wrong end, or a thread that is never retired, shows up there as a wrong order or a wrong transaction count. Inactive threads placed in a leader's line catch a mask that ignores the enable. An empty instruction catches a design that hangs or emits a phantom transaction. Overlapping and end-of-line stores expose a wrong winner or an out-of-line write. Random backpressure catches a design that advances while the cache stalls or that mistimes out_done.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int THREADS    = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DATA_W     = 32,
  parameter int CHAN_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LB        = LINE_BYTES * 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_store,
  input  logic [THREADS-1:0]        in_active,
  input  logic [THREADS*ADDR_W-1:0] in_addr,
  input  logic [THREADS*DATA_W-1:0] in_wdata,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_store,
  output logic [LA_W-1:0]           out_line,
  output logic [THREADS-1:0]        out_mask,
  output logic [THREADS*OFF_W-1:0]  out_offs,
  output logic [LB-1:0]             out_wdata,
  output logic [LINE_BYTES-1:0]     out_be,
  output logic                      out_done
);
  localparam int DB   = DATA_W / 8;
  localparam int TI_W = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam int BURST_BYTES = CHAN_W;

  logic [THREADS-1:0] pend;
  logic               store_q;
  logic [ADDR_W-1:0]  addr_q [THREADS];
  logic [DATA_W-1:0]  wdat_q [THREADS];
  logic [TI_W-1:0]    lead;
  logic [LA_W-1:0]    lead_line;
  logic [THREADS-1:0] rest;

  always_comb begin
    lead = '0;
    for (int t = THREADS - 1; t >= 0; t--)
      if (pend[t]) lead = TI_W'(t);
  end

  assign lead_line = addr_q[lead][ADDR_W-1:OFF_W];

  genvar g;
  generate
    for (g = 0; g < THREADS; g++) begin : g_thr
      assign out_mask[g] = pend[g] && (addr_q[g][ADDR_W-1:OFF_W] == lead_line);
      assign out_offs[g*OFF_W +: OFF_W] = out_mask[g] ? addr_q[g][OFF_W-1:0] : '0;
    end
  endgenerate

  always_comb begin
    logic [OFF_W:0] pos;
    out_be    = '0;
    out_wdata = '0;
    pos       = '0;
    if (store_q) begin
      for (int t = 0; t < THREADS; t++) begin
        if (out_mask[t]) begin
          for (int b = 0; b < DB; b++) begin
            pos = {1'b0, addr_q[t][OFF_W-1:0]} + (OFF_W+1)'(b);
            if (pos < (OFF_W+1)'(LINE_BYTES)) begin
              out_be[pos[OFF_W-1:0]] = 1'b1;
              out_wdata[{pos[OFF_W-1:0], 3'b000} +: 8] = wdat_q[t][b*8 +: 8];
            end
          end
        end
      end
    end
  end

  assign rest      = pend & ~out_mask;
  assign in_ready  = ~|pend;
  assign out_valid = |pend;
  assign out_store = store_q;
  assign out_line  = lead_line;
  assign out_done  = (out_valid && out_ready && rest == '0) ||
                     (in_valid && in_ready && in_active == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      store_q <= 1'b0;
      for (int t = 0; t < THREADS; t++) begin
        addr_q[t] <= '0;
        wdat_q[t] <= '0;
      end
    end else if (in_valid && in_ready) begin
      pend    <= in_active;
      store_q <= in_store;
      for (int t = 0; t < THREADS; t++) begin
        addr_q[t] <= in_addr[t*ADDR_W +: ADDR_W];
        wdat_q[t] <= in_wdata[t*DATA_W +: DATA_W];
      end
    end else if (out_valid && out_ready) begin
      pend <= rest;
    end
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_line)
                                   && $stable(out_offs) && $stable(out_be)));

  p_leader_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask[lead]);

  p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> ((pend & $past(out_mask)) == '0));

  p_mask_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~pend) == '0));

  p_done_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !(in_valid && in_ready)) |=> !out_valid);

  p_line_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (LINE_BYTES >= BURST_BYTES));
endmodule

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int T     = 8;
  localparam int AW    = 32;
  localparam int LINE  = 64;
  localparam int DW    = 32;
  localparam int OFF   = $clog2(LINE);
  localparam int LAW   = AW - OFF;
  localparam int LB    = LINE * 8;
  localparam int DB    = DW / 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_store = 0, out_ready = 0;
  logic [T-1:0] in_active = '0;
  logic [T*AW-1:0] in_addr = '0;
  logic [T*DW-1:0] in_wdata = '0;
  logic in_ready, out_valid, out_store, out_done;
  logic [LAW-1:0] out_line;
  logic [T-1:0] out_mask;
  logic [T*OFF-1:0] out_offs;
  logic [LB-1:0] out_wdata;
  logic [LINE-1:0] out_be;

  int checks = 0, failures = 0, cyc = 0;
  logic [AW-1:0] ta [T];
  logic [DW-1:0] td [T];
  logic [T-1:0] tact;
  logic tst;

  always #2 clk = ~clk;

  warp_coalescer #(.THREADS(T), .ADDR_W(AW), .LINE_BYTES(LINE), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store),
    .in_active(in_active), .in_addr(in_addr), .in_wdata(in_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_store(out_store), .out_line(out_line), .out_mask(out_mask),
    .out_offs(out_offs), .out_wdata(out_wdata), .out_be(out_be), .out_done(out_done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [T-1:0] f_mask(input logic [T-1:0] p);
    int ld = -1;
    logic [T-1:0] m = '0;
    for (int t = 0; t < T; t++) if (p[t] && ld < 0) ld = t;
    if (ld < 0) return '0;
    for (int t = 0; t < T; t++) m[t] = p[t] && (ta[t] >> OFF) == (ta[ld] >> OFF);
    return m;
  endfunction

  function automatic logic [LAW-1:0] f_line(input logic [T-1:0] p);
    for (int t = 0; t < T; t++) if (p[t]) return LAW'(ta[t] >> OFF);
    return '0;
  endfunction

  function automatic logic [T*OFF-1:0] f_offs(input logic [T-1:0] m);
    logic [T*OFF-1:0] o = '0;
    for (int t = 0; t < T; t++) if (m[t]) o[t*OFF +: OFF] = ta[t][OFF-1:0];
    return o;
  endfunction

  function automatic logic [LB-1:0] f_wd(input logic [T-1:0] m, input bit be_only);
    logic [LB-1:0] w = '0;
    logic [LINE-1:0] be = '0;
    if (tst)
      for (int t = 0; t < T; t++)
        if (m[t])
          for (int b = 0; b < DB; b++) begin
            int pos = int'(ta[t][OFF-1:0]) + b;
            if (pos < LINE) begin
              be[pos] = 1'b1;
              w[pos*8 +: 8] = td[t][b*8 +: 8];
            end
          end
    return be_only ? LB'(be) : w;
  endfunction

  function automatic int f_lines(input logic [T-1:0] a);
    int n = 0;
    logic [T-1:0] p = a;
    while (p != '0) begin
      p = p & ~f_mask(p);
      n++;
    end
    return n;
  endfunction

  task automatic run_instr(input int stall_pct, input bit junk);
    logic [T-1:0] pend;
    int ntx = 0, guard = 0;
    @(negedge clk);
    while (!in_ready && guard < 50) begin @(negedge clk); guard++; end
    for (int t = 0; t < T; t++) begin
      in_addr[t*AW +: AW] = ta[t];
      in_wdata[t*DW +: DW] = td[t];
    end
    in_active = tact; in_store = tst; in_valid = 1; out_ready = 0;
    #1;
    chk(in_ready == 1, "R2 idle ready", LB'(in_ready), 1);
    if (tact == '0) chk(out_done == 1, "R5 empty done", LB'(out_done), 1);
    @(negedge clk);
    in_valid = junk;
    in_active = junk ? ~tact : '0;
    in_addr = {T{32'h00ABC000}};
    pend = tact;
    if (tact == '0) chk(out_valid == 0, "R5 empty no tx", LB'(out_valid), 0);
    while (pend != '0 && guard < 2000) begin
      logic [T-1:0] m;
      logic r;
      guard++;
      r = ($urandom_range(0, 99) >= stall_pct);
      out_ready = r;
      #1;
      m = f_mask(pend);
      chk(out_valid == 1, "R4 valid while pending", LB'(out_valid), 1);
      chk(in_ready == 0, "R2 busy not ready", LB'(in_ready), 0);
      chk(out_mask == m, "R3 mask", LB'(out_mask), LB'(m));
      chk((out_mask & ~tact) == '0, "R5 inactive excluded", LB'(out_mask), LB'(m));
      chk(out_line == f_line(pend), "R3 line", LB'(out_line), LB'(f_line(pend)));
      chk(out_offs == f_offs(m), "R7 offsets", LB'(out_offs), LB'(f_offs(m)));
      chk(out_store == tst, "R8 store flag", LB'(out_store), LB'(tst));
      chk(out_be == LINE'(f_wd(m, 1)), "R8 byte enables", LB'(out_be), f_wd(m, 1));
      chk(out_wdata == f_wd(m, 0), "R8 write data", out_wdata, f_wd(m, 0));
      chk(out_done == (r && (pend & ~m) == '0), "R9 done", LB'(out_done),
          LB'(r && (pend & ~m) == '0));
      if (!r) begin
        @(negedge clk);
        chk(out_mask == m, "R6 hold mask", LB'(out_mask), LB'(m));
        continue;
      end
      pend = pend & ~m;
      ntx++;
      @(negedge clk);
    end
    in_valid = 0; out_ready = 0;
    chk(ntx == f_lines(tact), "R4 transaction count", LB'(ntx), LB'(f_lines(tact)));
    if (tact != '0 && f_lines(tact) == $countones(tact))
      chk(ntx == $countones(tact), "R11 divergent count", LB'(ntx), LB'($countones(tact)));
  endtask

  initial begin
    logic [AW-1:0] base;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 reset valid", LB'(out_valid), 0);
    chk(out_done == 0, "R1 reset done", LB'(out_done), 0);
    chk(in_ready == 1, "R1 reset ready", LB'(in_ready), 1);
    @(negedge clk); rst_n = 1;

    // R3 convergent: all threads in one line
    for (int t = 0; t < T; t++) begin ta[t] = 32'h1000 + 32'(t * 4); td[t] = $urandom; end
    tact = '1; tst = 0; run_instr(0, 0);

    // R11 divergent: one line per thread
    for (int t = 0; t < T; t++) ta[t] = 32'h2000 + 32'((T - t) * LINE);
    tact = '1; tst = 1; run_instr(20, 1);

    // R5 empty instruction
    tact = '0; run_instr(0, 0);

    // R5 inactive threads in leader line
    for (int t = 0; t < T; t++) ta[t] = (t % 2 == 0) ? 32'h3000 : 32'h3100 + 32'(t);
    tact = 8'b0101_0010; tst = 0; run_instr(0, 0);

    // R10 line edge
    ta[0] = 32'h4000; ta[1] = 32'h4000 + LINE - 1; ta[2] = 32'h4000 + LINE; ta[3] = 32'h4000 - 1;
    for (int t = 4; t < T; t++) ta[t] = ta[t % 4];
    tact = '1; tst = 0; run_instr(0, 0);
    chk(f_lines(tact) == 3, "R10 edge split", LB'(f_lines(tact)), 3);

    // R8 overlap (higher thread wins) and clipping at line end
    for (int t = 0; t < T; t++) begin ta[t] = 32'h5000 + 32'(t % 2) * (LINE - 2); td[t] = 32'hA0A0A000 + 32'(t); end
    tact = '1; tst = 1; run_instr(30, 0);

    // random mix, R2 junk offers, R6 stalls
    for (int n = 0; n < 300; n++) begin
      base = $urandom & ~32'(LINE - 1) & 32'h00FF_FFFF;
      for (int t = 0; t < T; t++) begin
        ta[t] = base + 32'($urandom_range(0, 3) * LINE) + 32'($urandom_range(0, LINE - 1));
        td[t] = $urandom;
      end
      tact = T'($urandom); tst = $urandom_range(0, 1);
      run_instr($urandom_range(0, 60), $urandom_range(0, 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial void'($urandom(32'h5eed));
endmodule